// File: doc/BRIEF.md
# Burst Packet Transmit Framer

This block turns one radio packet, given in parallel, into a serial bit stream. A packet is made of four fields sent back to back. First comes a short alternating preamble. Next come the low bits of a destination address, with the count of bits set at run time. Then come the payload bits. Last comes an optional 8-bit or 16-bit checksum computed over the address and payload bits. Inside each field the most significant bit goes first.

The host sets a 24-bit configuration word, the address, a payload buffer with its bit count and the preamble length, then pulses `start`. Bits leave at the rate of `bitEn`, one bit per enabled cycle. Address, payload and checksum together share a budget of 256 bits. If a start request breaks that budget, or asks for too wide an address, the block raises a one-cycle error and sends nothing.

Top module: `burst_framer`

## Requirements
- R1: After reset, `busy`, `txValid`, `done` and `err` are all low.
- R2: Every packet begins with a preamble of alternating bits starting with 1. The preamble is 4 bits when `preLong` is 0 and 8 bits when it is 1.
- R3: Configuration bits 23:18 give the address width W (0 to 40). After the preamble, bits W-1 down to 0 of `dstAddr` are sent. Higher address bits are never sent.
- R4: After the address, bits `payLen`-1 down to 0 of `payload` are sent. A `payLen` of 0 sends no payload.
- R5: When configuration bit 16 is 0, no checksum follows the payload.
- R6: When bit 16 is 1 and bit 17 is 0, an 8-bit checksum follows. It uses polynomial 0x07 and starts from 0xFF, covers the address and payload bits, and is sent MSB first.
- R7: When bits 16 and 17 are both 1, a 16-bit checksum follows. It uses polynomial 0x1021, starts from 0xFFFF, and covers the same bits.
- R8: A start with W above 40 raises `err` for exactly the next cycle. No bit is sent and `busy` stays low.
- R9: A start with `payLen` above 256 - W - C raises `err` in the same way, where C is 0, 8 or 16 as the checksum setting gives. A `payLen` equal to that limit is accepted.
- R10: `txValid` is high only in the cycle after a cycle where `bitEn` was high, and each enabled cycle during a packet gives exactly one bit.
- R11: `busy` rises the cycle after an accepted start and stays high until `done`. `done` pulses for one cycle, one cycle after the last `txValid`, and `busy` is low in that cycle.
- R12: A `start` while `busy` is high is ignored: the packet in flight is unchanged and `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 24 | Configuration: [23:18] address width, [17] long checksum, [16] checksum enable |
| dstAddr | input | 40 | Destination address, right-aligned |
| payload | input | 256 | Payload buffer, right-aligned |
| payLen | input | 9 | Payload length in bits |
| preLong | input | 1 | 1 selects the 8-bit preamble, 0 the 4-bit preamble |
| start | input | 1 | Start request strobe |
| bitEn | input | 1 | Bit-rate enable, one bit per high cycle |
| txBit | output | 1 | Serial data bit |
| txValid | output | 1 | `txBit` is valid this cycle |
| busy | output | 1 | A packet is in flight |
| done | output | 1 | One-cycle pulse after the last bit |
| err | output | 1 | One-cycle pulse when a start request is rejected |

## Verification
When the design samples `start`, a reject shows as `err` in the next cycle, and an accept shows as `busy` in that same next cycle. The serial outputs are registered, so a bit enabled by `bitEn` in one cycle appears in the following cycle. `done` comes one cycle later than the last valid bit. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each read sees the result of exactly one rising edge. The bench keeps the cycle of the last valid bit and of `done` and compares them. Each received field is compared with a stream that the bench computes from the inputs alone.

// File: rtl/burst_framer_pkg.sv
package burst_framer_pkg;
  localparam int BUDGET_BITS = 256;
  localparam int ADDR_MAX    = 40;
  localparam int LEN_W       = $clog2(BUDGET_BITS + 1);
  localparam int PIDX_W      = $clog2(BUDGET_BITS);
  localparam int AIDX_W      = $clog2(ADDR_MAX);
  localparam int CFG_W       = 24;
  localparam int AW_HI       = 23;
  localparam int AW_LO       = 18;
  localparam int CRC_LONG_B  = 17;
  localparam int CRC_EN_B    = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_ADDR, PH_PAY, PH_CRC, PH_FIN
  } phase_t;

  typedef struct packed {
    logic             load;
    logic             emit;
    logic             crcUpd;
    phase_t           phase;
    logic [LEN_W-1:0] pos;
  } ctrl_strb_t;
endpackage

// File: rtl/burst_framer_ctrl.sv
module burst_framer_ctrl
  import burst_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [5:0]       awIn,
  input  logic             crcLong,
  input  logic             crcOn,
  input  logic [LEN_W-1:0] payLen,
  input  logic             preLong,
  input  logic             start,
  input  logic             bitEn,
  output ctrl_strb_t       strb,
  output logic             busy,
  output logic             done,
  output logic             err
);
  phase_t           state;
  logic [LEN_W-1:0] pos;
  logic [5:0]       awQ;
  logic [LEN_W-1:0] lenQ;
  logic [4:0]       crcLenQ;

  logic [4:0]       crcLenIn;
  logic [LEN_W-1:0] limit;
  logic             reqBad;
  logic             accept;
  logic             active;
  logic             emit;
  phase_t           nxtPh;
  logic [LEN_W-1:0] nxtLen;

  assign crcLenIn = crcOn ? (crcLong ? 5'd16 : 5'd8) : 5'd0;
  assign limit    = LEN_W'(BUDGET_BITS) - LEN_W'(awIn) - LEN_W'(crcLenIn);
  assign reqBad   = (awIn > 6'(ADDR_MAX)) || (payLen > limit);
  assign accept   = start && (state == PH_IDLE) && !reqBad;
  assign active   = (state == PH_PRE) || (state == PH_ADDR) ||
                    (state == PH_PAY) || (state == PH_CRC);
  assign emit     = bitEn && active;

  // Next non-empty field after the current one
  always_comb begin
    nxtPh  = PH_FIN;
    nxtLen = '0;
    if (state == PH_PRE && awQ != 6'd0) begin
      nxtPh  = PH_ADDR;
      nxtLen = LEN_W'(awQ);
    end else if ((state == PH_PRE || state == PH_ADDR) && lenQ != '0) begin
      nxtPh  = PH_PAY;
      nxtLen = lenQ;
    end else if ((state == PH_PRE || state == PH_ADDR || state == PH_PAY) &&
                 crcLenQ != 5'd0) begin
      nxtPh  = PH_CRC;
      nxtLen = LEN_W'(crcLenQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      pos     <= '0;
      awQ     <= '0;
      lenQ    <= '0;
      crcLenQ <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= (state == PH_FIN);
      err  <= start && (state == PH_IDLE) && reqBad;
      case (state)
        PH_IDLE: if (accept) begin
          state   <= PH_PRE;
          pos     <= preLong ? LEN_W'(7) : LEN_W'(3);
          awQ     <= awIn;
          lenQ    <= payLen;
          crcLenQ <= crcLenIn;
        end
        PH_FIN: state <= PH_IDLE;
        default: if (emit) begin
          if (pos == '0) begin
            state <= nxtPh;
            pos   <= (nxtPh == PH_FIN) ? '0 : LEN_W'(nxtLen - 1'b1);
          end else begin
            pos <= pos - 1'b1;
          end
        end
      endcase
    end
  end

  assign busy        = (state != PH_IDLE);
  assign strb.load   = accept;
  assign strb.emit   = emit;
  assign strb.crcUpd = emit && (state == PH_ADDR || state == PH_PAY);
  assign strb.phase  = state;
  assign strb.pos    = pos;

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));
  p_addr_in_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ADDR) |-> (LEN_W'(awQ) > pos));
  p_crc_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_CRC) |-> (crcLenQ != 5'd0));
  p_len_in_budget_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((9'(awQ) + 9'(crcLenQ) + {1'b0, lenQ[LEN_W-2:0]}) <= 9'(BUDGET_BITS)
              || lenQ == LEN_W'(BUDGET_BITS)));
endmodule

// File: rtl/burst_framer_dp.sv
module burst_framer_dp
  import burst_framer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strb_t             strb,
  input  logic [ADDR_MAX-1:0]    dstAddr,
  input  logic [BUDGET_BITS-1:0] payload,
  input  logic                   crcLong,
  output logic                   txBit,
  output logic                   txValid
);
  logic [ADDR_MAX-1:0]    addrQ;
  logic [BUDGET_BITS-1:0] payQ;
  logic                   wideQ;
  logic [15:0]            crcQ;
  logic                   curBit;
  logic [15:0]            crcNext;
  logic                   unusedPos;

  assign unusedPos = strb.pos[LEN_W-1];

  always_comb begin
    case (strb.phase)
      PH_PRE:  curBit = strb.pos[0];
      PH_ADDR: curBit = addrQ[strb.pos[AIDX_W-1:0]];
      PH_PAY:  curBit = payQ[strb.pos[PIDX_W-1:0]];
      PH_CRC:  curBit = wideQ ? crcQ[strb.pos[3:0]] : crcQ[strb.pos[2:0]];
      default: curBit = 1'b0;
    endcase
  end

  // Two checksum engines; the latched width picks the one in use
  for (genvar g = 0; g < 2; g++) begin : g_crc
    localparam int CW = (g == 0) ? 8 : 16;
    localparam logic [CW-1:0] POLY = (g == 0) ? CW'(8'h07) : CW'(16'h1021);
    logic [CW-1:0] cur;
    logic [CW-1:0] nxt;
    logic          fb;
    assign cur = crcQ[CW-1:0];
    assign fb  = cur[CW-1] ^ curBit;
    assign nxt = {cur[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crcNext = wideQ ? g_crc[1].nxt : {8'h00, g_crc[0].nxt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      payQ    <= '0;
      wideQ   <= 1'b0;
      crcQ    <= '0;
      txBit   <= 1'b0;
      txValid <= 1'b0;
    end else begin
      txValid <= strb.emit;
      if (strb.emit) txBit <= curBit;
      if (strb.load) begin
        addrQ <= dstAddr;
        payQ  <= payload;
        wideQ <= crcLong;
        crcQ  <= crcLong ? 16'hFFFF : 16'h00FF;
      end else if (strb.crcUpd) begin
        crcQ <= crcNext;
      end
    end
  end

  p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_CRC) |=> $stable(crcQ));
  p_narrow_crc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wideQ && strb.phase != PH_IDLE) |-> (crcQ[15:8] == 8'h00));
endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import burst_framer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CFG_W-1:0]       cfgWord,
  input  logic [ADDR_MAX-1:0]    dstAddr,
  input  logic [BUDGET_BITS-1:0] payload,
  input  logic [LEN_W-1:0]       payLen,
  input  logic                   preLong,
  input  logic                   start,
  input  logic                   bitEn,
  output logic                   txBit,
  output logic                   txValid,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);
  ctrl_strb_t strb;
  logic       unusedCfg;

  assign unusedCfg = ^cfgWord[CRC_EN_B-1:0];

  burst_framer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .awIn    (cfgWord[AW_HI:AW_LO]),
    .crcLong (cfgWord[CRC_LONG_B]),
    .crcOn   (cfgWord[CRC_EN_B]),
    .payLen  (payLen),
    .preLong (preLong),
    .start   (start),
    .bitEn   (bitEn),
    .strb    (strb),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  burst_framer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dstAddr (dstAddr),
    .payload (payload),
    .crcLong (cfgWord[CRC_LONG_B]),
    .txBit   (txBit),
    .txValid (txValid)
  );

  p_valid_needs_en_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(bitEn));
  p_valid_in_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);
  p_no_err_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !err);
endmodule

// File: tb/sim_burst_framer.sv
module sim_burst_framer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [23:0]  cfgWord = '0;
  logic [39:0]  dstAddr = '0;
  logic [255:0] payload = '0;
  logic [8:0]   payLen = '0;
  logic         preLong = 1'b0;
  logic         start = 1'b0;
  logic         bitEn = 1'b0;
  logic         txBit, txValid, busy, done, err;

  int checks = 0;
  int fails  = 0;
  bit expBits [0:299];
  int expN;
  bit rxBits [0:319];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_framer u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .dstAddr(dstAddr),
    .payload(payload), .payLen(payLen), .preLong(preLong), .start(start),
    .bitEn(bitEn), .txBit(txBit), .txValid(txValid), .busy(busy),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcBit(input logic [15:0] c, input bit b, input bit wide);
    logic [15:0] r;
    if (wide) begin
      r = {c[14:0], 1'b0};
      if (c[15] ^ b) r = r ^ 16'h1021;
    end else begin
      r = {8'h00, c[6:0], 1'b0};
      if (c[7] ^ b) r = r ^ 16'h0007;
    end
    return r;
  endfunction

  task automatic buildExp(input bit pre8, input int aw, input bit crcEn, input bit crcL,
                          input logic [39:0] a, input logic [255:0] p, input int len);
    logic [15:0] c;
    expN = 0;
    for (int i = 0; i < (pre8 ? 8 : 4); i++) begin expBits[expN] = (i % 2 == 0); expN++; end
    c = crcL ? 16'hFFFF : 16'h00FF;
    for (int i = aw - 1; i >= 0; i--) begin
      expBits[expN] = a[i]; expN++; c = crcBit(c, a[i], crcL);
    end
    for (int i = len - 1; i >= 0; i--) begin
      expBits[expN] = p[i]; expN++; c = crcBit(c, p[i], crcL);
    end
    if (crcEn)
      for (int i = (crcL ? 15 : 7); i >= 0; i--) begin expBits[expN] = c[i]; expN++; end
  endtask

  function automatic logic [255:0] rndPay();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic runGood(input int aw, input bit crcEn, input bit crcL, input bit pre8,
                         input int len, input int enPct, input bit restrike);
    int got = 0, lastV = -1, doneAt = -1, cyc = 0, badEn = 0, badBusy = 0, sawErr = 0;
    int preBad = 0, adBad = 0, pyBad = 0, ckBad = 0, preN, k;
    bit prevEn;
    logic [39:0]  a;
    logic [255:0] p;
    a = {$urandom, $urandom};
    p = rndPay();
    buildExp(pre8, aw, crcEn, crcL, a, p, len);
    @(negedge clk);
    cfgWord = {6'(aw), crcL, crcEn, 16'h0};
    dstAddr = a; payload = p; payLen = 9'(len); preLong = pre8;
    start = 1'b1; bitEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    check(err == 1'b0, "R9 accepted start no err", err, 0);
    while (doneAt < 0 && cyc < 3000) begin
      prevEn = (($urandom % 100) < enPct);
      bitEn = prevEn;
      start = (restrike && cyc == 10);
      @(negedge clk);
      cyc++;
      if (txValid) begin
        if (!prevEn) badEn++;
        if (got < 320) rxBits[got] = txBit;
        got++;
        lastV = cyc;
      end
      if (err) sawErr++;
      if (done) doneAt = cyc;
      else if (!busy) badBusy++;
    end
    start = 1'b0; bitEn = 1'b0;
    check(got == expN, "R10 bit count", got, expN);
    check(badEn == 0, "R10 valid without enable", badEn, 0);
    check(doneAt == lastV + 1, "R11 done timing", doneAt, lastV + 1);
    check(badBusy == 0 && busy == 1'b0, "R11 busy span", badBusy, 0);
    check(sawErr == 0, "R12 no err in flight", sawErr, 0);
    preN = pre8 ? 8 : 4;
    for (int i = 0; i < expN && i < got; i++) begin
      k = rxBits[i] != expBits[i];
      if (i < preN) preBad += k;
      else if (i < preN + aw) adBad += k;
      else if (i < preN + aw + len) pyBad += k;
      else ckBad += k;
    end
    check(preBad == 0, "R2 preamble", preBad, 0);
    check(adBad == 0, "R3 address", adBad, 0);
    check(pyBad == 0, "R4 payload", pyBad, 0);
    if (!crcEn)     check(expN == preN + aw + len, "R5 no checksum", got, preN + aw + len);
    else if (!crcL) check(ckBad == 0, "R6 crc8", ckBad, 0);
    else            check(ckBad == 0, "R7 crc16", ckBad, 0);
  endtask

  task automatic runBad(input int aw, input bit crcEn, input bit crcL, input int len, input string tag);
    @(negedge clk);
    cfgWord = {6'(aw), crcL, crcEn, 16'h0};
    payLen = 9'(len); start = 1'b1; bitEn = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, tag, err, 1);
    check(busy == 1'b0, tag, busy, 0);
    @(negedge clk);
    check(err == 1'b0 && txValid == 1'b0 && busy == 1'b0, tag, {err, txValid, busy}, 0);
    bitEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int aw, cl, len;
    bit ce, cL;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, txValid, done, err} == 4'b0, "R1 reset state", {busy, txValid, done, err}, 0);

    runGood(40, 1, 1, 0, 200, 100, 0);     // R9 exact limit with crc16
    runGood(0, 0, 0, 1, 256, 70, 1);       // R5 full budget, R12 restrike
    runGood(32, 1, 0, 1, 216, 90, 1);      // R6 limit with crc8
    runGood(5, 1, 1, 0, 0, 60, 0);         // R4 empty payload
    runGood(0, 0, 1, 0, 0, 100, 0);        // preamble only
    runBad(41, 1, 0, 0, "R8 width 41");
    runBad(63, 0, 0, 10, "R8 width 63");
    runBad(40, 1, 1, 201, "R9 over limit crc16");
    runBad(0, 0, 0, 257, "R9 over full budget");
    runBad(10, 1, 0, 239, "R9 over limit crc8");

    for (int n = 0; n < 20; n++) begin
      aw = $urandom % 41;
      ce = $urandom % 2;
      cL = $urandom % 2;
      cl = ce ? (cL ? 16 : 8) : 0;
      len = $urandom % (257 - aw - cl);
      runGood(aw, ce, cL, $urandom % 2, len, 40 + ($urandom % 61), len > 40);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule